// File: doc/BRIEF.md
# OTP Programming Unlock Guard

This block protects the programming path of a one-time-programmable memory controller. The programming path stays locked until software completes a fixed unlock ritual. Software selects the unlock command and places one key value in the write-data register. It then raises the start strobe. The four key values must arrive through four such starts, in strict order. When the last key is accepted, the guard raises a sticky program-permit signal to the command engine and sets its program-ok status output.

Each start of the unlock command returns a one-cycle step-done pulse, which software waits for before it drops start and moves to the next key. A wrong key ends the attempt. So does any other command started in the middle of the sequence, or a start of the relock command. After any of these, the sequence has to begin again from its first value. The relock command clears the permit and reports completion with a one-cycle pulse on the program-ok output. The guard holds no memory array and no bus decoding: it sees a decoded command code, the start strobe and the data register.

Top module: `otp_unlock_guard`

## Requirements
- R1: Synchronous reset clears the key progress, the permit, the program-ok output and the step-done output. A partial key sequence entered before reset gives no credit afterwards.
- R2: A rising edge of start with command code 6'h02 gives one step-done pulse, exactly one cycle wide, in the cycle after that edge. This holds whether or not the key matches.
- R3: Four rising starts with command 6'h02 unlock programming when wdata carries 32'h0000000F, 32'h00000004, 32'h00000008 and 32'h0000000D, in that order. Permit and program-ok rise in the cycle after the fourth edge and stay high until relock or reset.
- R4: A start of command 6'h02 whose wdata differs from the expected key sends progress back to the first key value. Later keys then do not unlock until the full sequence is repeated from 32'h0000000F.
- R5: A rising start with any command code other than 6'h02 or 6'h03 gives no step-done pulse. It also discards any partial key progress.
- R6: Start held high for several cycles counts as a single step. Only a low-to-high transition of start is accepted.
- R7: A rising start with command 6'h03 clears the permit in the next cycle. In that same cycle program-ok is high for exactly one cycle, and then it drops. No step-done pulse is given.
- R8: Relock discards any partial key progress, so a complete fresh four-key sequence is needed to unlock again.
- R9: Fewer than four correct keys never raise the permit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 6 | Decoded command field (6'h02 unlock step, 6'h03 relock) |
| start | input | 1 | Start strobe; each rising edge issues one command |
| wdata | input | 32 | Write-data register holding the key value |
| step_done | output | 1 | One-cycle pulse for each accepted unlock step |
| prog_ok | output | 1 | Program-ok status: high while unlocked, one-cycle pulse on relock |
| prog_permit | output | 1 | Sticky permit driven to the command engine |

## Verification
Some properties are checked on every cycle. The step-done pulse is one cycle wide and only follows an unlock-command start. A held start never yields a second pulse. Permit always implies program-ok. The permit only rises right after a final-key unlock start. Relock clears the permit and pulses program-ok. Other behaviour depends on history that no single property sees, so only the bench's directed scenarios show it: the ordering of the key, the reset of progress by a wrong key, a foreign command or relock, and the need for a full fresh sequence after relock or reset.

// File: rtl/otp_unlock_pkg.sv
package otp_unlock_pkg;

  localparam int CMD_W   = 6;
  localparam int DATA_W  = 32;
  localparam int KEY_LEN = 4;

  localparam logic [CMD_W-1:0] CMD_UNLOCK = 6'h02;
  localparam logic [CMD_W-1:0] CMD_RELOCK = 6'h03;

  // classified event for one clock
  typedef enum logic [2:0] {
    EV_IDLE    = 3'd0,
    EV_KEY_OK  = 3'd1,
    EV_KEY_FIN = 3'd2,
    EV_KEY_BAD = 3'd3,
    EV_FOREIGN = 3'd4,
    EV_RELOCK  = 3'd5
  } guard_ev_t;

  // key value expected at step idx (order is behaviour)
  function automatic logic [3:0] key_value(input int unsigned idx);
    case (idx)
      0:       key_value = 4'hF;
      1:       key_value = 4'h4;
      2:       key_value = 4'h8;
      default: key_value = 4'hD;
    endcase
  endfunction

endpackage

// File: rtl/otp_start_edge.sv
module otp_start_edge (
  input  logic clk,
  input  logic start,
  output logic rise
);
  logic start_q;

  // follows start even in reset so a strobe held across reset is not an edge
  always_ff @(posedge clk) begin
    start_q <= start;
  end

  assign rise = start & ~start_q;
endmodule

// File: rtl/otp_cmd_classify.sv
module otp_cmd_classify
  import otp_unlock_pkg::*;
#(
  parameter int CW    = CMD_W,
  parameter int DW    = DATA_W,
  parameter int KLEN  = KEY_LEN,
  localparam int IW   = (KLEN > 1) ? $clog2(KLEN) : 1
) (
  input  logic          rise,
  input  logic [CW-1:0] cmd_code,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] step_idx,
  output guard_ev_t     ev
);
  logic [DW-1:0] expect_word;
  logic          key_match;
  logic          last_step;

  always_comb begin
    expect_word = DW'(key_value(int'(step_idx)));
    key_match   = (wdata == expect_word);
    last_step   = (int'(step_idx) == KLEN - 1);
    ev          = EV_IDLE;
    if (rise) begin
      if (cmd_code == CW'(CMD_UNLOCK)) begin
        if (!key_match)     ev = EV_KEY_BAD;
        else if (last_step) ev = EV_KEY_FIN;
        else                ev = EV_KEY_OK;
      end else if (cmd_code == CW'(CMD_RELOCK)) begin
        ev = EV_RELOCK;
      end else begin
        ev = EV_FOREIGN;
      end
    end
  end
endmodule

// File: rtl/otp_key_seq.sv
module otp_key_seq
  import otp_unlock_pkg::*;
#(
  parameter int KLEN = KEY_LEN,
  localparam int IW  = (KLEN > 1) ? $clog2(KLEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  guard_ev_t     ev,
  output logic [IW-1:0] step_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step_idx <= '0;
    end else begin
      case (ev)
        EV_KEY_OK:  step_idx <= step_idx + IW'(1);
        EV_KEY_FIN,
        EV_KEY_BAD,
        EV_FOREIGN,
        EV_RELOCK:  step_idx <= '0;
        default:    step_idx <= step_idx;
      endcase
    end
  end
endmodule

// File: rtl/otp_permit_reg.sv
module otp_permit_reg
  import otp_unlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  guard_ev_t ev,
  output logic      step_done,
  output logic      prog_ok,
  output logic      prog_permit
);
  logic permit_nxt;
  logic is_step;

  always_comb begin
    is_step    = (ev == EV_KEY_OK) || (ev == EV_KEY_FIN) || (ev == EV_KEY_BAD);
    permit_nxt = prog_permit;
    if (ev == EV_KEY_FIN) permit_nxt = 1'b1;
    if (ev == EV_RELOCK)  permit_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_done   <= 1'b0;
      prog_ok     <= 1'b0;
      prog_permit <= 1'b0;
    end else begin
      step_done   <= is_step;
      prog_permit <= permit_nxt;
      prog_ok     <= permit_nxt | (ev == EV_RELOCK);
    end
  end
endmodule

// File: rtl/otp_unlock_guard.sv
module otp_unlock_guard
  import otp_unlock_pkg::*;
#(
  parameter int CW   = CMD_W,
  parameter int DW   = DATA_W,
  parameter int KLEN = KEY_LEN,
  localparam int IW  = (KLEN > 1) ? $clog2(KLEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cmd_code,
  input  logic          start,
  input  logic [DW-1:0] wdata,
  output logic          step_done,
  output logic          prog_ok,
  output logic          prog_permit
);
  logic          rise;
  logic [IW-1:0] step_idx;
  guard_ev_t     ev;

  otp_start_edge u_edge (
    .clk   (clk),
    .start (start),
    .rise  (rise)
  );

  otp_cmd_classify #(.CW(CW), .DW(DW), .KLEN(KLEN)) u_cls (
    .rise     (rise),
    .cmd_code (cmd_code),
    .wdata    (wdata),
    .step_idx (step_idx),
    .ev       (ev)
  );

  otp_key_seq #(.KLEN(KLEN)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .step_idx (step_idx)
  );

  otp_permit_reg u_perm (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .step_done   (step_done),
    .prog_ok     (prog_ok),
    .prog_permit (prog_permit)
  );
endmodule

// File: rtl/otp_unlock_guard_chk.sv
module otp_unlock_guard_chk
  import otp_unlock_pkg::*;
#(
  parameter int CW   = CMD_W,
  parameter int DW   = DATA_W,
  parameter int KLEN = KEY_LEN
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cmd_code,
  input logic          start,
  input logic [DW-1:0] wdata,
  input logic          step_done,
  input logic          prog_ok,
  input logic          prog_permit
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done); // R2
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    step_done |-> ($past(start) && $past(cmd_code) == CW'(CMD_UNLOCK))); // R2
  AST_HELD_START_ONCE: assert property (@(posedge clk) disable iff (rst)
    (start && $past(start)) |=> !step_done); // R6
  AST_PERMIT_HAS_OK: assert property (@(posedge clk) disable iff (rst)
    prog_permit |-> prog_ok); // R3
  AST_UNLOCK_LAST_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_permit) |-> ($past(cmd_code) == CW'(CMD_UNLOCK) &&
                            $past(wdata) == DW'(key_value(KLEN - 1)))); // R3
  AST_RELOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (start && cmd_code == CW'(CMD_RELOCK)) |=> !prog_permit); // R7
  AST_RELOCK_ACK: assert property (@(posedge clk) disable iff (rst)
    (start && !$past(start) && cmd_code == CW'(CMD_RELOCK)) |=> (prog_ok && !step_done)); // R7
endmodule

bind otp_unlock_guard otp_unlock_guard_chk #(.CW(CW), .DW(DW), .KLEN(KLEN)) u_chk (.*);

// File: tb/tb_otp_unlock_guard.sv
module tb_otp_unlock_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cmd_code = '0;
  logic        start = 1'b0;
  logic [31:0] wdata = '0;
  logic        step_done, prog_ok, prog_permit;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit over  = 0;
  logic s_done, s_ok, s_perm;

  localparam logic [5:0] UNL = 6'h02;
  localparam logic [5:0] REL = 6'h03;

  always #5 clk = ~clk;

  otp_unlock_guard dut (.*);

  task automatic chk(input bit pass, input string tag, input int act, input int exp);
    total++;
    if (!pass) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // one command: raise start, sample one edge later, drop start
  task automatic step(input logic [5:0] c, input logic [31:0] d);
    @(negedge clk); cmd_code = c; wdata = d; start = 1'b1;
    @(negedge clk); s_done = step_done; s_ok = prog_ok; s_perm = prog_permit;
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic full_key();
    step(UNL, 32'hF); step(UNL, 32'h4); step(UNL, 32'h8); step(UNL, 32'hD);
  endtask

  task automatic t_reset();
    do_reset();
    chk(prog_permit == 0, "R1 permit after reset", prog_permit, 0);
    chk(prog_ok == 0, "R1 ok after reset", prog_ok, 0);
    chk(step_done == 0, "R1 done after reset", step_done, 0);
  endtask

  task automatic t_unlock();
    step(UNL, 32'hF);
    chk(s_done == 1, "R2 done on step1", s_done, 1);
    chk(s_perm == 0, "R9 no permit after 1 key", s_perm, 0);
    chk(step_done == 0, "R2 done one cycle only", step_done, 0);
    step(UNL, 32'h4);
    step(UNL, 32'h8);
    chk(s_perm == 0 && s_ok == 0, "R9 no permit after 3 keys", s_perm, 0);
    step(UNL, 32'hD);
    chk(s_done == 1, "R2 done on final step", s_done, 1);
    chk(s_perm == 1, "R3 permit after key", s_perm, 1);
    chk(s_ok == 1, "R3 ok after key", s_ok, 1);
    repeat (5) @(negedge clk);
    chk(prog_permit == 1 && prog_ok == 1, "R3 permit sticky", prog_permit, 1);
  endtask

  task automatic t_relock();
    step(REL, 32'h0);
    chk(s_perm == 0, "R7 permit cleared", s_perm, 0);
    chk(s_ok == 1, "R7 ok ack pulse", s_ok, 1);
    chk(s_done == 0, "R7 no done on relock", s_done, 0);
    chk(prog_ok == 0, "R7 ok drops after pulse", prog_ok, 0);
  endtask

  task automatic t_fresh();
    step(UNL, 32'hF); step(UNL, 32'h4);
    step(REL, 32'h0);
    step(UNL, 32'h8); step(UNL, 32'hD);
    chk(prog_permit == 0, "R8 partial lost on relock", prog_permit, 0);
    full_key();
    chk(prog_permit == 1, "R8 fresh sequence unlocks", prog_permit, 1);
    step(REL, 32'h0);
  endtask

  task automatic t_wrong();
    step(UNL, 32'hF); step(UNL, 32'h4);
    step(UNL, 32'h7);
    chk(s_done == 1, "R2 done on wrong key", s_done, 1);
    step(UNL, 32'h8); step(UNL, 32'hD);
    chk(prog_permit == 0, "R4 wrong key restarts", prog_permit, 0);
    step(UNL, 32'hF); step(UNL, 32'h4); step(UNL, 32'h8); step(UNL, 32'h1000000D);
    chk(prog_permit == 0, "R4 upper bits count", prog_permit, 0);
    full_key();
    chk(prog_permit == 1, "R4 retry unlocks", prog_permit, 1);
    step(REL, 32'h0);
  endtask

  task automatic t_foreign();
    step(UNL, 32'hF); step(UNL, 32'h4);
    step(6'h00, 32'h8);
    chk(s_done == 0, "R5 no done on other cmd", s_done, 0);
    step(UNL, 32'h8); step(UNL, 32'hD);
    chk(prog_permit == 0, "R5 other cmd restarts", prog_permit, 0);
  endtask

  task automatic t_hold();
    int pulses = 0;
    step(UNL, 32'hF);
    @(negedge clk); cmd_code = UNL; wdata = 32'h4; start = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (step_done) pulses++;
    end
    start = 1'b0;
    @(negedge clk);
    chk(pulses == 1, "R6 held start one pulse", pulses, 1);
    step(UNL, 32'h8); step(UNL, 32'hD);
    chk(prog_permit == 1, "R6 held start counted once", prog_permit, 1);
    step(REL, 32'h0);
  endtask

  task automatic t_reset_mid();
    full_key();
    do_reset();
    chk(prog_permit == 0, "R1 reset clears permit", prog_permit, 0);
    step(UNL, 32'hF); step(UNL, 32'h4);
    do_reset();
    step(UNL, 32'h8); step(UNL, 32'hD);
    chk(prog_permit == 0, "R1 reset clears progress", prog_permit, 0);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !over) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_unlock();
    t_relock();
    t_fresh();
    t_wrong();
    t_foreign();
    t_hold();
    t_reset_mid();
    finish_run();
  end
endmodule